// File: doc/BRIEF.md
# Configuration Length Count Comparator

This block decides when a device has finished loading its configuration. A cycle counter starts with the first configuration clock after reset or after a program request. It counts every clock, including any that arrive before the stream's preamble or before valid data. The expected total is read from a length field in the serial stream. The block holds it in a register and compares it with the counter.

The done indication rises only when two things are true at the same time: the frame loader reports that configuration memory is full, and the counter equals the stored length exactly. If the memory fills on a different count, the block raises a mismatch flag. The counter then keeps running, wraps through zero and meets the length again one full counter period later. So a stray extra clock costs a full wrap of the counter.

Done is presented in open-drain form. The drive enable pulls the pin low while configuration is incomplete. The pin level reads high only when done is set and a pull-up is enabled.

Top module: `cfg_length_gate`

## Requirements
- R1: While reset is asserted, the pin level is 0, the pull-low enable is 1 and the mismatch flag is 0.
- R2: The cycle counter advances by one on every clock from the first clock after reset or program request, and is never gated by valid data.
- R3: The length register shifts in `sdata_i` MSB first on each clock where both `sdata_vld_i` and `len_fld_i` are 1, until CNT_W bits are held. Clocks where either input is 0 do not shift. Further strobed bits after the field is complete are ignored.
- R4: Done becomes 1 at the clock edge where `mem_full_i` is 1, the length is complete, and the counter value before that edge equals the length.
- R5: The mismatch flag becomes 1 when `mem_full_i` rises while the counter differs from the length or the length is incomplete. It stays 1 until reset or program request.
- R6: When the count is missed, done rises on the first later edge where the counter, taken modulo 2^CNT_W, again equals the length.
- R7: Once set, done stays 1 regardless of `mem_full_i` until reset or program request, and the counter holds.
- R8: `done_pull_low_o` is 1 exactly while done is 0. `done_pin_o` is 1 only when done is 1 and `pullup_en_i` is 1.
- R9: A clock edge with `prog_req_i` at 1 clears done, mismatch, counter and length. The next edge counts as the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| prog_req_i | input | 1 | Synchronous restart of configuration |
| sdata_i | input | 1 | Serial configuration data |
| sdata_vld_i | input | 1 | Data bit valid strobe |
| len_fld_i | input | 1 | Marks bits belonging to the length field |
| mem_full_i | input | 1 | Frame loader reports configuration memory full |
| pullup_en_i | input | 1 | Pull-up option on the done pin |
| done_pin_o | output | 1 | Level seen on the open-drain done pin |
| done_pull_low_o | output | 1 | Drive enable pulling the done pin low |
| mismatch_o | output | 1 | Memory filled on a count other than the length |

## Verification
The assertions assume all inputs are synchronous to the configuration clock. They also assume that `mem_full_i`, once raised, stays high until the next program request, so that each rise marks one fill event. The bench changes inputs only on the falling edge. It holds memory-full high from its chosen edge to the end of each case and issues a program request before every case.

// File: rtl/cfglen_pkg.sv
package cfglen_pkg;
  localparam int unsigned DEF_CNT_W = 24;

  typedef enum logic [0:0] {
    PH_RUN  = 1'b0,
    PH_DONE = 1'b1
  } phase_e;
endpackage

// File: rtl/cfglen_rst_sync.sv
module cfglen_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/cfglen_cycle_ctr.sv
module cfglen_cycle_ctr #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i | ~hold_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)        cnt_d = '0;
    else if (!hold_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2 / R6: unconditional step, wrapping modulo 2^CNT_W
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !hold_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R7: frozen once done
  assert_cnt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && hold_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cfglen_len_reg.sv
module cfglen_len_reg #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sdata_i,
  input  logic             vld_i,
  input  logic             fld_i,
  output logic [CNT_W-1:0] len_o,
  output logic             full_o
);
  localparam int unsigned BC_W = $clog2(CNT_W + 1);
  localparam logic [BC_W-1:0] BC_MAX = BC_W'(CNT_W);

  logic [CNT_W-1:0] len_q, len_d;
  logic [BC_W-1:0]  bc_q, bc_d;
  logic             full, shift, reg_en;

  assign full   = (bc_q == BC_MAX);
  assign shift  = vld_i & fld_i & ~full;
  assign reg_en = clr_i | shift;

  always_comb begin
    len_d = len_q;
    bc_d  = bc_q;
    if (clr_i) begin
      len_d = '0;
      bc_d  = '0;
    end else if (shift) begin
      len_d = {len_q[CNT_W-2:0], sdata_i};
      bc_d  = bc_q + BC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      bc_q  <= '0;
    end else if (reg_en) begin
      len_q <= len_d;
      bc_q  <= bc_d;
    end
  end

  assign len_o  = len_q;
  assign full_o = full;

  // R3: newest bit enters at the LSB (MSB-first field)
  assert_len_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && fld_i && !full && !clr_i) |=> len_q[0] == $past(sdata_i));

  // R3: complete field ignores further bits
  assert_len_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !clr_i) |=> $stable(len_q));
endmodule

// File: rtl/cfglen_done_ctl.sv
module cfglen_done_ctl
  import cfglen_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             mem_full_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             len_full_i,
  output logic             done_o,
  output logic             mism_o
);
  phase_e ph_q, ph_d;
  logic   mism_q, mism_d;
  logic   mf_q;
  logic   match, mf_rise;

  assign match   = len_full_i & (cnt_i == len_i);
  assign mf_rise = mem_full_i & ~mf_q;

  always_comb begin
    ph_d   = ph_q;
    mism_d = mism_q;
    if (clr_i) begin
      ph_d   = PH_RUN;
      mism_d = 1'b0;
    end else if (ph_q == PH_RUN) begin
      if (mem_full_i && match) ph_d = PH_DONE;
      if (mf_rise && !match)   mism_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_RUN;
      mism_q <= 1'b0;
      mf_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      mism_q <= mism_d;
      mf_q   <= mem_full_i & ~clr_i;
    end
  end

  assign done_o = (ph_q == PH_DONE);
  assign mism_o = mism_q;

  // R4: done only on full memory with an exact count
  assert_done_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(mem_full_i) && $past(cnt_i) == $past(len_i)));

  // R7: sticky done
  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o);

  // R5: sticky mismatch
  assert_mism_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mism_o && !clr_i) |=> mism_o);

  // R9: program request clears status
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!done_o && !mism_o));
endmodule

// File: rtl/cfg_length_gate.sv
module cfg_length_gate
  import cfglen_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_req_i,
  input  logic sdata_i,
  input  logic sdata_vld_i,
  input  logic len_fld_i,
  input  logic mem_full_i,
  input  logic pullup_en_i,
  output logic done_pin_o,
  output logic done_pull_low_o,
  output logic mismatch_o
);
  logic             rst_n;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;
  logic             len_full;
  logic             done;

  cfglen_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  cfglen_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (prog_req_i),
    .hold_i (done),
    .cnt_o  (cnt)
  );

  cfglen_len_reg #(.CNT_W(CNT_W)) u_len (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .clr_i   (prog_req_i),
    .sdata_i (sdata_i),
    .vld_i   (sdata_vld_i),
    .fld_i   (len_fld_i),
    .len_o   (len),
    .full_o  (len_full)
  );

  cfglen_done_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .clr_i      (prog_req_i),
    .mem_full_i (mem_full_i),
    .cnt_i      (cnt),
    .len_i      (len),
    .len_full_i (len_full),
    .done_o     (done),
    .mism_o     (mismatch_o)
  );

  assign done_pull_low_o = ~done;
  assign done_pin_o      = done & pullup_en_i;

  // R8: pin never reads high while it is being pulled low
  assert_pin_od_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_pin_o |-> !done_pull_low_o);
endmodule

// File: tb/sim_cfg_length_gate.sv
module sim_cfg_length_gate;
  localparam int W = 8;
  localparam int MOD = 1 << W;
  localparam int NV = 7;
  // stimulus table: length value, edge at which memory-full rises
  localparam int VLEN [NV] = '{20, 40, 30, 9, 255, 100, 0};
  localparam int VFUL [NV] = '{21, 20, 32, 10, 100, 3, 200};

  logic clk = 1'b0;
  logic rst_n, prog, sd, vld, fld, mf, pu;
  logic pin, pull_low, mism;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfg_length_gate #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .prog_req_i(prog), .sdata_i(sd),
    .sdata_vld_i(vld), .len_fld_i(fld), .mem_full_i(mf), .pullup_en_i(pu),
    .done_pin_o(pin), .done_pull_low_o(pull_low), .mismatch_o(mism)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int len, input int f, input bit gap);
    int k = 0;
    int first = 0;
    int exp_e = f;
    bit exp_m;
    while (((exp_e - 1) % MOD) != len) exp_e++;
    exp_m = ((f - 1) != len);
    @(negedge clk); prog = 1'b1; mf = 1'b0; vld = 1'b0; fld = 1'b0;
    @(negedge clk); prog = 1'b0;
    for (int e = 1; e <= exp_e + 3; e++) begin
      vld = 1'b0; fld = 1'b0; sd = 1'b0;
      if (k < W && (!gap || (e % 2) == 1)) begin
        vld = 1'b1; fld = 1'b1; sd = 1'((len >> (W - 1 - k)) & 1); k++;
      end else if (k < W) begin
        sd = ~1'((len >> (W - 1 - k)) & 1);
        if ((e % 4) == 0) fld = 1'b1; else vld = 1'b1;
      end else if (gap && k < W + 3) begin
        vld = 1'b1; fld = 1'b1; sd = 1'b1; k++;
      end
      mf = (e >= f);
      @(negedge clk);
      if (pin && first == 0) first = e;
    end
    check(exp_m ? "R6 done edge" : "R4 done edge", first, exp_e);
    check("R5 mismatch", int'(mism), int'(exp_m));
    check("R8 pull low", int'(pull_low), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prog = 1'b0; sd = 1'b0; vld = 1'b0; fld = 1'b0; mf = 1'b0; pu = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pin", int'(pin), 0);
    check("R1 pull low", int'(pull_low), 1);
    check("R1 mismatch", int'(mism), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) run_case(VLEN[i], VFUL[i], 1'b0);

    // R7: done sticky with memory-full dropped
    mf = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 done sticky", int'(pin), 1);

    // R8: no pull-up -> pin low, not driven
    pu = 1'b0; #1;
    check("R8 pin without pullup", int'(pin), 0);
    check("R8 pull low released", int'(pull_low), 0);
    pu = 1'b1; #1;
    check("R8 pin with pullup", int'(pin), 1);

    // R9: program request clears done and mismatch
    check("R9 mismatch before", int'(mism), 1);
    prog = 1'b1;
    @(negedge clk); prog = 1'b0;
    check("R9 done cleared", int'(pin), 0);
    check("R9 pull low", int'(pull_low), 1);
    check("R9 mismatch cleared", int'(mism), 0);

    // R3: gaps and surplus field bits ignored
    run_case(50, 51, 1'b1);
    run_case(77, 60, 1'b1);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0; #1;
    check("R1 async pin", int'(pin), 0);
    check("R1 async pull low", int'(pull_low), 1);
    check("R1 async mismatch", int'(mism), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule